// File: doc/BRIEF.md
# Streaming Array Read Engine

This block carries out the data phase of a serial flash read command. Once an external decoder has recognised the read opcode, it strobes `rd_cmd`. The engine then collects a 24-bit start address from the serial input, one bit on each rising serial clock edge. Next it fetches bytes through a registered, byte-wide memory read port. Each byte goes out on the serial output, most significant bit first, and the output changes after falling serial clock edges.

The address advances by one after each byte. It wraps from the top of the 128 KiB array back to zero, so a single command can stream the array without end. Deselecting the device ends the stream at any bit. If the internal write-cycle flag is set when the strobe arrives, the command is refused. In that case the output stays released and the memory port stays idle until select goes high.

All serial inputs are sampled on the system clock `clk`, and the serial front end delivers them already synchronised. Each serial clock phase must last at least four system clock cycles, so that the next byte arrives before it is needed.

Top module: `read_stream_engine`

## Requirements
- R1: After `rd_cmd` with select low and `busy` low, the next 24 rising `sclk` edges shift in the start address, most significant bit first, from `mosi`.
- R2: The first byte output comes from the start address, which may be any byte in a page. Each following byte comes from the previous address plus one.
- R3: Only the low 17 address bits are used, and the upper 7 received bits have no effect. After address 0x1FFFF the next byte comes from 0x00000.
- R4: Each byte is sent most significant bit first. A new bit appears on `so_data` after each falling `sclk` edge. The first bit follows the first falling edge after the last address bit. Bytes follow one another without a gap, and `so_en` stays high until select goes high.
- R5: While `cs_n` is high, `so_en` is low. Raising `cs_n` at any bit position ends the read, and the next transaction starts from scratch.
- R6: If `busy` is high when `rd_cmd` arrives, no memory fetch is issued and `so_en` stays low until `cs_n` goes high.
- R7: During and right after reset, `so_en` and `mem_en` are low.
- R8: Each fetch is a one-cycle `mem_en` pulse with `mem_addr`, and the byte is taken from `mem_rdata` one cycle later. One fetch is issued at the end of the address, plus one more at the start of each byte output. The extra fetch prefetches the byte that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, sampled on `clk` |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| rd_cmd | input | 1 | One-cycle strobe: read opcode decoded |
| busy | input | 1 | Internal program/erase/status-write cycle in progress |
| so_data | output | 1 | Serial data out value |
| so_en | output | 1 | Output driver enable (low means high impedance) |
| mem_en | output | 1 | Memory read strobe |
| mem_addr | output | 17 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_en` |

## Verification
The hardest condition to reach is the wrap from the last array byte to byte zero during a single stream. The start address must be placed just below the top, and the stream must run across the boundary. The stimulus therefore starts one read at 0x1FFFE with junk in the upper address bits and another at 0x1FFFF, each running past the top. Termination is placed mid-byte, right after a prefetch was issued, to show that the pending fetch does not leak into the next transaction.

// File: rtl/read_stream_engine.sv
module read_stream_engine #(
  parameter int ADDR_BITS  = 24,
  parameter int ARRAY_BITS = 17,
  parameter int DATA_BITS  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  input  logic                  rd_cmd,
  input  logic                  busy,
  output logic                  so_data,
  output logic                  so_en,
  output logic                  mem_en,
  output logic [ARRAY_BITS-1:0] mem_addr,
  input  logic [DATA_BITS-1:0]  mem_rdata
);
  localparam int ACW = $clog2(ADDR_BITS + 1);
  localparam int BCW = $clog2(DATA_BITS);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_REJ} st_t;

  st_t                  st;
  logic                 sclk_q;
  logic [ACW-1:0]       acnt;
  logic [ARRAY_BITS-1:0] ashift;
  logic [BCW-1:0]       bcnt;
  logic [DATA_BITS-1:0] sh;
  logic [DATA_BITS-1:0] nxt;
  logic                 nxt_ok;
  logic                 en_q;
  logic                 q;

  wire rise = sclk & ~sclk_q;
  wire fall = ~sclk & sclk_q;
  wire [ARRAY_BITS-1:0] afull = {ashift[ARRAY_BITS-2:0], mosi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sclk_q   <= 1'b0;
      acnt     <= '0;
      ashift   <= '0;
      bcnt     <= '0;
      sh       <= '0;
      nxt      <= '0;
      nxt_ok   <= 1'b0;
      en_q     <= 1'b0;
      q        <= 1'b0;
      mem_en   <= 1'b0;
      mem_addr <= '0;
    end else begin
      sclk_q <= sclk;
      mem_en <= 1'b0;
      en_q   <= mem_en;
      if (en_q) begin
        nxt    <= mem_rdata;
        nxt_ok <= 1'b1;
      end
      if (cs_n) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (rd_cmd) begin
            st   <= busy ? S_REJ : S_ADDR;
            acnt <= '0;
            bcnt <= '0;
            q    <= 1'b0;
          end
          S_ADDR: if (rise) begin
            ashift <= afull;
            acnt   <= acnt + 1'b1;
            if (acnt == ACW'(ADDR_BITS - 1)) begin
              mem_addr <= afull;
              mem_en   <= 1'b1;
              nxt_ok   <= 1'b0;
              st       <= S_DATA;
            end
          end
          S_DATA: if (fall) begin
            if (bcnt == '0) begin
              if (nxt_ok) begin
                q        <= nxt[DATA_BITS-1];
                sh       <= nxt << 1;
                nxt_ok   <= 1'b0;
                mem_addr <= mem_addr + 1'b1;
                mem_en   <= 1'b1;
                bcnt     <= BCW'(1);
              end
            end else begin
              q    <= sh[DATA_BITS-1];
              sh   <= sh << 1;
              bcnt <= (bcnt == BCW'(DATA_BITS - 1)) ? '0 : bcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign so_en   = (st == S_DATA) & ~cs_n;
  assign so_data = q;
endmodule

// File: rtl/read_stream_checker.sv
module read_stream_checker #(
  parameter int ARRAY_BITS = 17
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  rd_cmd,
  input logic                  busy,
  input logic                  so_en,
  input logic                  mem_en,
  input logic [ARRAY_BITS-1:0] mem_addr
);
  logic                  active, rej, seen;
  logic [ARRAY_BITS-1:0] last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rej    <= 1'b0;
      seen   <= 1'b0;
      last   <= '0;
    end else if (cs_n) begin
      active <= 1'b0;
      rej    <= 1'b0;
      seen   <= 1'b0;
    end else begin
      if (rd_cmd && !active) begin
        active <= 1'b1;
        rej    <= busy;
      end
      if (mem_en) begin
        seen <= 1'b1;
        last <= mem_addr;
      end
    end
  end

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rej |-> !so_en && !mem_en); // R6
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && seen |-> mem_addr == ARRAY_BITS'(last + 1'b1)); // R2
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) |-> !so_en && !mem_en); // R5
  AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    so_en && !cs_n |=> so_en || cs_n); // R4
  AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en); // R8
endmodule

bind read_stream_engine read_stream_checker #(.ARRAY_BITS(ARRAY_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cmd(rd_cmd), .busy(busy),
  .so_en(so_en), .mem_en(mem_en), .mem_addr(mem_addr)
);

// File: tb/test_read_stream_engine.sv
`timescale 1ns/1ps
module test_read_stream_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        rd_cmd = 1'b0;
  logic        busy = 1'b0;
  logic        so_data, so_en, mem_en;
  logic [16:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [16:0] exp_q[$];

  always #10 clk = ~clk;

  read_stream_engine i_read_stream_engine (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .rd_cmd(rd_cmd), .busy(busy), .so_data(so_data), .so_en(so_en),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pattern(input logic [16:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ {a[16], 7'h2A};
  endfunction

  always @(posedge clk) if (mem_en) mem_rdata <= pattern(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (mem_en) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected fetch", int'(mem_addr), -1);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk(mem_addr == e, "R2 fetch address", int'(mem_addr), int'(e));
      end
    end
    if (cs_n && so_en) chk(1'b0, "R5 enable while deselected", 1, 0);
  end

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic read_txn(input logic [23:0] addr, input int nbits, input bit bsy, input string req);
    logic [16:0] a;
    a = addr[16:0];
    cs_n = 1'b0;
    busy = bsy;
    half();
    rd_cmd = 1'b1;
    @(negedge clk);
    rd_cmd = 1'b0;
    if (!bsy) for (int k = 0; k <= (nbits + 7) / 8; k++) exp_q.push_back(a + 17'(k));
    for (int i = 23; i >= 0; i--) begin
      sclk = 1'b0;
      mosi = addr[i];
      half();
      sclk = 1'b1;
      half();
    end
    for (int j = 0; j < nbits; j++) begin
      logic [16:0] ba;
      logic [7:0]  bv;
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      ba = a + 17'(j / 8);
      bv = pattern(ba);
      if (bsy) chk(so_en == 1'b0, "R6 output released on refused read", so_en, 0);
      else begin
        chk(so_en == 1'b1, "R4 output enabled during stream", so_en, 1);
        chk(so_data == bv[7 - (j % 8)], req, so_data, bv[7 - (j % 8)]);
      end
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      half();
    end
    @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(so_en == 1'b0, "R5 released after deselect", so_en, 0);
    sclk = 1'b0;
    half();
    chk(exp_q.size() == 0, "R8 fetch count", exp_q.size(), 0);
    exp_q.delete();
    busy = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(so_en == 1'b0, "R7 so_en in reset", so_en, 0);
    chk(mem_en == 1'b0, "R7 mem_en in reset", mem_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(so_en == 1'b0 && mem_en == 1'b0, "R7 idle after reset", {so_en, mem_en}, 0);
    read_txn(24'h000010, 24, 1'b0, "R1,R2 plain read data");
    read_txn(24'hAB0045, 16, 1'b0, "R3 upper bits ignored, mid-page start");
    read_txn(24'hFFFFFE, 32, 1'b0, "R3 wrap across top of array");
    read_txn(24'h000123, 13, 1'b0, "R4,R5 stream ended mid-byte");
    read_txn(24'h00F0F0, 16, 1'b0, "R5 fresh read after mid-byte end");
    read_txn(24'h000000, 10, 1'b1, "R6 refused read");
    read_txn(24'h01FFFF, 12, 1'b0, "R3,R6 read after refusal wraps");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule